// File: doc/BRIEF.md
# Raster Line and Frame Counter

This block turns elapsed processor clock cycles into video scanline and frame timing. Each clock it adds a small cycle count to an accumulator. When the total reaches one full scanline (1728 cycles by default), the line counter advances by one and the excess cycles stay in the accumulator for the next line, so no time is lost. Lines are counted modulo the frame height (312 by default).

At each line completion the block looks at the line that has just finished, before the counter moves on. It emits a one-cycle pulse when that line is the fixed vertical-blank line (240), another when it equals a software-programmed compare line, and a frame-start pulse when the finished line is the last of the frame. The pulses are meant to set interrupt status bits in a separate interrupt controller. The same three events are also packed into a 16-bit event word, with the frame-start flag at bit 8. The current line number can be read at any time.

Top module: `raster_counter`

## Requirements
- R1: Each clock adds `cyc_add` to a cycle accumulator. When the sum reaches 1728 or more, one line completes and the accumulator keeps the sum minus 1728, so excess cycles carry into the next line.
- R2: `line_num` shows the current line, zero-extended to 16 bits. It increases by exactly one on the clock edge where a line completes and is otherwise unchanged.
- R3: After line 311 completes, `line_num` returns to 0, so its value always stays below 312.
- R4: `vblank_pulse` is high for exactly one cycle, on the edge where line 240 completes (the same edge where `line_num` becomes 241).
- R5: `match_pulse` is high for exactly one cycle, on the edge where the completing line equals `cmp_line` as sampled on that edge.
- R6: A `cmp_line` value of 312 or more never produces `match_pulse`.
- R7: `frame_start_pulse` is high for exactly one cycle, on the edge where line 311 completes (the same edge where `line_num` becomes 0).
- R8: `event_word` is bit 0 = vertical-blank pulse, bit 1 = line-match pulse, bit 8 = frame-start pulse, with all other bits 0.
- R9: A synchronous active-low reset clears the accumulator, the line counter and all pulses. After reset the first line needs a full 1728 cycles.
- R10: While `cyc_add` is 0, neither the accumulator nor the line counter changes, and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_add | input | 4 | Cycles elapsed in this clock |
| cmp_line | input | 16 | Programmable line for the match event |
| line_num | output | 16 | Current line number |
| vblank_pulse | output | 1 | Vertical-blank line completed |
| match_pulse | output | 1 | Compare line completed |
| frame_start_pulse | output | 1 | Last line of the frame completed; new frame begins |
| event_word | output | 16 | Packed event flags (bits 0, 1, 8) |

## Verification
The assertions assume that `cyc_add` is always less than one line of cycles, so that at most one line completes per clock. They also assume the parameters place the vertical-blank line below the last line. The stimulus keeps `cyc_add` between 0 and 15, which stays far under 1728. It changes `cmp_line` only while the accumulator is far from a line boundary, or while `cyc_add` is held at 0. Full frames are driven at 15 cycles per clock, and carry behaviour is tested with a step of 7, which does not divide the line length evenly.

// File: rtl/raster_pkg.sv
// Package: shared event layout for the raster line/frame counter.
// Assumes: an event-word consumer decodes the bit positions below.
package raster_pkg;
    localparam int EVB_VBLANK = 0;
    localparam int EVB_MATCH  = 1;
    localparam int EVB_FRAME  = 8;

    typedef struct packed {
        logic vblank;
        logic match;
        logic frame;
    } raster_evt_t;
endpackage

// File: rtl/rc_cycle_accum.sv
// Module: rc_cycle_accum
// Adds the per-clock cycle count into an accumulator and signals a completed
// line when the sum reaches CYC_PER_LINE, keeping the excess cycles.
// Assumes: cyc_add never reaches CYC_PER_LINE, so at most one line per clock.
module rc_cycle_accum #(
    parameter int CYC_PER_LINE = 1728,
    parameter int STEP_W       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STEP_W-1:0] cyc_add,
    output logic              line_tick
);
    localparam int ACC_W = $clog2(CYC_PER_LINE);
    localparam int SUM_W = ACC_W + 1;

    logic [ACC_W-1:0] acc_q;
    logic [SUM_W-1:0] sum;

    // Purpose: form the running sum and decide whether a line completes.
    always_comb begin
        sum       = {1'b0, acc_q} + SUM_W'(cyc_add);
        line_tick = (sum >= SUM_W'(CYC_PER_LINE));
    end

    // Purpose: hold the accumulated cycles, carrying any excess past a line.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (line_tick)
            acc_q <= ACC_W'(sum - SUM_W'(CYC_PER_LINE));
        else
            acc_q <= ACC_W'(sum);
    end

    // R1: the carried remainder always stays below one line.
    assert_acc_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < ACC_W'(CYC_PER_LINE));

    // R10: an idle clock leaves the accumulator untouched.
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_add == '0) |=> $stable(acc_q));
endmodule

// File: rtl/rc_line_counter.sv
// Module: rc_line_counter
// Counts completed lines modulo LINES_PER_FRAME and flags the wrap cycle.
// Assumes: line_tick is a single-cycle qualifier from the cycle accumulator.
module rc_line_counter #(
    parameter int LINES_PER_FRAME = 312,
    parameter int LN_W            = $clog2(LINES_PER_FRAME)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_tick,
    output logic [LN_W-1:0] line_q,
    output logic            wrap
);
    localparam logic [LN_W-1:0] LAST_LINE = LN_W'(LINES_PER_FRAME - 1);

    // Purpose: detect completion of the last line of the frame.
    always_comb wrap = line_tick && (line_q == LAST_LINE);

    // Purpose: advance the line number, returning to zero after the last line.
    always_ff @(posedge clk) begin
        if (!rst_n)
            line_q <= '0;
        else if (wrap)
            line_q <= '0;
        else if (line_tick)
            line_q <= line_q + 1'b1;
    end

    // R3: completing the last line brings the counter back to zero.
    assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (line_tick && line_q == LAST_LINE) |=> (line_q == '0));

    // R2: without a completed line the counter holds.
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !line_tick |=> $stable(line_q));
endmodule

// File: rtl/rc_event_detect.sv
// Module: rc_event_detect
// Evaluates the finishing line against the fixed blanking line and the
// programmable compare value, and registers one-cycle event pulses.
// Assumes: line_cur is the line before it advances on the same edge.
module rc_event_detect #(
    parameter int LINES_PER_FRAME = 312,
    parameter int VBLANK_LINE     = 240,
    parameter int LN_W            = 9,
    parameter int CMP_W           = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   line_tick,
    input  logic                   wrap,
    input  logic [LN_W-1:0]        line_cur,
    input  logic [CMP_W-1:0]       cmp_line,
    output raster_pkg::raster_evt_t evt_q
);
    logic cmp_in_range;
    logic cmp_hit;
    logic vbl_hit;

    // Purpose: decide which line events apply to the line now finishing.
    always_comb begin
        cmp_in_range = (cmp_line < CMP_W'(LINES_PER_FRAME));
        cmp_hit      = cmp_in_range && (CMP_W'(line_cur) == cmp_line);
        vbl_hit      = (line_cur == LN_W'(VBLANK_LINE));
    end

    // Purpose: register the pulses for exactly the completing cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= '0;
        end else begin
            evt_q.vblank <= line_tick && vbl_hit;
            evt_q.match  <= line_tick && cmp_hit;
            evt_q.frame  <= wrap;
        end
    end
endmodule

// File: rtl/raster_counter.sv
// Module: raster_counter (top)
// Converts per-clock cycle counts into scanline and frame timing and raises
// vertical-blank, line-compare and frame-start pulses.
// Assumes: cyc_add stays below CYC_PER_LINE; VBLANK_LINE < LINES_PER_FRAME - 1.
module raster_counter #(
    parameter int CYC_PER_LINE    = 1728,
    parameter int LINES_PER_FRAME = 312,
    parameter int VBLANK_LINE     = 240,
    parameter int STEP_W          = 4,
    parameter int OUT_W           = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STEP_W-1:0] cyc_add,
    input  logic [OUT_W-1:0]  cmp_line,
    output logic [OUT_W-1:0]  line_num,
    output logic              vblank_pulse,
    output logic              match_pulse,
    output logic              frame_start_pulse,
    output logic [OUT_W-1:0]  event_word
);
    localparam int LN_W = $clog2(LINES_PER_FRAME);

    logic                    line_tick;
    logic                    wrap;
    logic [LN_W-1:0]         line_q;
    raster_pkg::raster_evt_t evt;

    rc_cycle_accum #(
        .CYC_PER_LINE (CYC_PER_LINE),
        .STEP_W       (STEP_W)
    ) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_add   (cyc_add),
        .line_tick (line_tick)
    );

    rc_line_counter #(
        .LINES_PER_FRAME (LINES_PER_FRAME),
        .LN_W            (LN_W)
    ) u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_tick (line_tick),
        .line_q    (line_q),
        .wrap      (wrap)
    );

    rc_event_detect #(
        .LINES_PER_FRAME (LINES_PER_FRAME),
        .VBLANK_LINE     (VBLANK_LINE),
        .LN_W            (LN_W),
        .CMP_W           (OUT_W)
    ) u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_tick (line_tick),
        .wrap      (wrap),
        .line_cur  (line_q),
        .cmp_line  (cmp_line),
        .evt_q     (evt)
    );

    // Purpose: present the line number and pulses at the ports.
    always_comb begin
        line_num          = OUT_W'(line_q);
        vblank_pulse      = evt.vblank;
        match_pulse       = evt.match;
        frame_start_pulse = evt.frame;
    end

    // Purpose: pack the pulses into the event word at their fixed positions.
    always_comb begin
        for (int b = 0; b < OUT_W; b++) begin
            event_word[b] = 1'b0;
        end
        event_word[raster_pkg::EVB_VBLANK] = evt.vblank;
        event_word[raster_pkg::EVB_MATCH]  = evt.match;
        event_word[raster_pkg::EVB_FRAME]  = evt.frame;
    end

    // R3: the visible line number never reaches the frame height.
    assert_line_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        line_num < OUT_W'(LINES_PER_FRAME));

    // R2: a line change is a single increment or the wrap to zero.
    assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_num != $past(line_num)) |->
        (line_num == $past(line_num) + 1'b1 || line_num == '0));

    // R4: blanking pulse lands as the counter leaves the blanking line.
    assert_vblank_pos_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_pulse |-> (line_num == OUT_W'(VBLANK_LINE + 1)));

    // R4: the blanking pulse lasts one cycle.
    assert_vblank_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_pulse |=> !vblank_pulse);

    // R5: a match pulse follows completion of the compared line.
    assert_match_pos_R5: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> ($past(line_num) == $past(cmp_line)));

    // R6: an out-of-range compare value never matched.
    assert_match_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> ($past(cmp_line) < OUT_W'(LINES_PER_FRAME)));

    // R7: frame-start coincides with the counter returning to zero.
    assert_frame_pos_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_pulse |-> (line_num == '0));
endmodule

// File: tb/raster_counter_tb.sv
// Directed bench for raster_counter with an independent timing model.
module raster_counter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CPL        = 1728;
    localparam int LPF        = 312;
    localparam int VBL        = 240;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cyc_add = '0;
    logic [15:0] cmp_line = 16'hFFFF;
    logic [15:0] line_num;
    logic        vblank_pulse, match_pulse, frame_start_pulse;
    logic [15:0] event_word;

    int checks = 0;
    int errors = 0;
    int cyc_cnt = 0;

    // model state
    int m_acc = 0;
    int m_line = 0;
    bit m_vb, m_mt, m_fr;
    int n_vb, n_mt, n_fr, d_vb, d_mt, d_fr;

    raster_counter u_dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .cyc_add           (cyc_add),
        .cmp_line          (cmp_line),
        .line_num          (line_num),
        .vblank_pulse      (vblank_pulse),
        .match_pulse       (match_pulse),
        .frame_start_pulse (frame_start_pulse),
        .event_word        (event_word)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc_cnt <= cyc_cnt + 1;
        if (cyc_cnt == WATCHDOG) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<%0d", cyc_cnt, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check_eq(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_counts();
        n_vb = 0; n_mt = 0; n_fr = 0; d_vb = 0; d_mt = 0; d_fr = 0;
    endtask

    // One clock: drive at negedge, update model after posedge, compare at negedge.
    task automatic step(input int add, input bit do_rst);
        int sum;
        cyc_add = 4'(add);
        rst_n   = !do_rst;
        @(posedge clk);
        if (do_rst) begin
            m_acc = 0; m_line = 0; m_vb = 0; m_mt = 0; m_fr = 0;
        end else begin
            sum = m_acc + add;
            m_vb = 0; m_mt = 0; m_fr = 0;
            if (sum >= CPL) begin
                m_acc = sum - CPL;
                m_vb  = (m_line == VBL);
                m_mt  = (m_line == int'(cmp_line));
                m_fr  = (m_line == LPF - 1);
                m_line = m_fr ? 0 : m_line + 1;
            end else begin
                m_acc = sum;
            end
        end
        @(negedge clk);
        if (line_num != 16'(m_line)) check_eq("R2 line_num", line_num, m_line);
        if (vblank_pulse != m_vb) check_eq("R4 vblank_pulse", vblank_pulse, m_vb);
        if (match_pulse != m_mt) check_eq("R5 match_pulse", match_pulse, m_mt);
        if (frame_start_pulse != m_fr) check_eq("R7 frame_start_pulse", frame_start_pulse, m_fr);
        if (event_word != {7'd0, m_fr, 6'd0, m_mt, m_vb})
            check_eq("R8 event_word", event_word, {7'd0, m_fr, 6'd0, m_mt, m_vb});
        n_vb += vblank_pulse; n_mt += match_pulse; n_fr += frame_start_pulse;
        d_vb += m_vb; d_mt += m_mt; d_fr += m_fr;
    endtask

    task automatic run(input int n, input int add);
        for (int i = 0; i < n; i++) step(add, 1'b0);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 4; i++) step(5, 1'b1);
        check_eq("R9 reset line_num", line_num, 0);
        check_eq("R9 reset event_word", event_word, 0);
        check_eq("R9 reset pulses", vblank_pulse + match_pulse + frame_start_pulse, 0);
    endtask

    task automatic t_carry();
        run(246, 7);
        check_eq("R1 before first line (1722 cycles)", line_num, 0);
        step(7, 1'b0);
        check_eq("R1 first line at 1729 cycles", line_num, 1);
        run(246, 7);
        check_eq("R1 carried cycle, 1723 total", line_num, 1);
        step(7, 1'b0);
        check_eq("R1 second line with carry", line_num, 2);
    endtask

    task automatic t_idle();
        int held;
        held = line_num;
        run(3000, 0);
        check_eq("R10 idle line unchanged", line_num, held);
        check_eq("R10 idle no events", n_vb + n_mt + n_fr, 0);
        step(0, 1'b0);
        run(247, 7);
        check_eq("R10 accumulator kept across idle", line_num, held + 1);
    endtask

    task automatic t_frame(input int cmp, input int exp_match);
        cmp_line = 16'(cmp);
        clear_counts();
        run(36000, 15);
        check_eq("R4 vblank count per frame", n_vb, d_vb);
        check_eq("R4 one vblank in frame", d_vb, 1);
        check_eq("R7 frame start count", n_fr, d_fr);
        check_eq("R3 one wrap in frame", d_fr, 1);
        check_eq("R5 match count", n_mt, d_mt);
        check_eq(exp_match != 0 ? "R5 match per frame" : "R6 no match", n_mt, exp_match);
    endtask

    task automatic t_reset_mid();
        step(0, 1'b1);
        check_eq("R9 mid-run reset line", line_num, 0);
        run(115, 15);
        check_eq("R9 full line needed after reset", line_num, 0);
        step(15, 1'b0);
        check_eq("R9 first line after reset", line_num, 1);
    endtask

    initial begin
        clear_counts();
        @(negedge clk);
        t_reset();
        t_carry();
        t_idle();
        t_frame(100, 1);
        t_frame(400, 0);
        t_frame(312, 0);
        t_frame(0, 1);
        t_reset_mid();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule